// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Controller

This block holds the control side of a byte-wide parallel NOR flash. It runs on a system clock and samples three active-low strobes: chip select, read enable and write enable. It also takes an address bus and an 8-bit data bus. The data bus reaches the block as a split input, output and output-enable trio, so the pad ring builds the tristate. Reads return the stored byte. Writes are decoded as unlock-and-command sequences that start a byte program, a whole-array erase or a permanent lock of a 16 KB boot window.

Program and erase time themselves with internal cycle counters. While either one runs, reads return a status byte, so software can poll for the end of the operation. The storage is a small register array sized for simulation. It is split into two halves. One half shadows the boot window and the other shadows the rest of the address space.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: With chip select low, read enable low and write enable high, `dq_oe` is 1 and `dq_out` carries the stored byte at `addr` whenever no operation is running.
- R2: `dq_oe` is 0 whenever chip select or read enable is high.
- R3: After reset every stored byte reads 0xFF, no lock is set and no operation is running.
- R4: Writes of 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, followed by a fourth write of (A, D), make the byte at A become its old value AND D. Only the low 15 address bits are compared for command addresses.
- R5: A write beat takes its address at the first clock at which both chip select and write enable are low. It takes its data at the first clock at which either of the two is high again.
- R6: A program keeps the block busy for exactly PROG_CYC clock cycles after the clock that captures its last beat.
- R7: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555 set every byte to 0xFF and keep the block busy for ERASE_CYC cycles.
- R8: The same six writes ending in 0x40 instead of 0x10 set the boot lock at once, with no busy period. No command, including erase, clears the lock.
- R9: Once locked, a program aimed at the boot window is ignored and starts no busy period, and an erase leaves the boot window's bytes unchanged.
- R10: While busy, a read returns {~D[7], 7'b0} for a program of data D, and 0x00 for an erase.
- R11: A write that does not match the next expected step returns the decoder to idle without starting anything. Writes made while busy are ignored.
- R12: The boot window is addresses whose bits above BOOT_AW are all zero (BOOT_TOP=0) or all one (BOOT_TOP=1). The storage index is {not-boot, addr[MEM_AW-2:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data bus value from the pad |
| dq_out | output | 8 | Data to drive onto the bus |
| dq_oe | output | 1 | Pad output enable for `dq_out` |

## Verification
The properties assume that each strobe stays low, and then high, for at least one full clock period. Without that, the controller cannot see a write overlap begin and then end. They also assume the data input is steady at the clock that closes a beat. The bench moves every input at the falling clock edge and holds each strobe level for whole periods, so every beat's opening and closing edges land on distinct rising edges. Its skewed-strobe write changes address and data only while the overlap is held, which keeps that assumption intact.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_DATA_A = 8'hAA;
    localparam logic [7:0] KEY_DATA_B = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_EXT   = 8'h80;
    localparam logic [7:0] CODE_ERASE = 8'h10;
    localparam logic [7:0] CODE_LOCK  = 8'h40;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PDATA,
        SQ_EXT,
        SQ_KEY3,
        SQ_KEY4
    } seq_t;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_PGM,
        REQ_ERS,
        REQ_LCK
    } req_kind_t;

    typedef struct packed {
        req_kind_t  kind;
        logic [7:0] data;
    } nfc_req_t;

    function automatic logic [7:0] prog_status(input logic [7:0] d);
        return {~d[7], 7'b0};
    endfunction

endpackage

// File: rtl/nfc_bus_latch.sv
module nfc_bus_latch #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [7:0]        beat_data
);

    logic              overlap;
    logic              overlap_q;
    logic [ADDR_W-1:0] addr_q;

    assign overlap = ~ce_n & ~we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            overlap_q <= 1'b0;
            addr_q    <= '0;
        end else begin
            overlap_q <= overlap;
            if (overlap && !overlap_q) begin
                addr_q <= addr;
            end
        end
    end

    assign beat_valid = overlap_q & ~overlap;
    assign beat_addr  = addr_q;
    assign beat_data  = dq_in;

endmodule

// File: rtl/nfc_seq_decode.sv
module nfc_seq_decode
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_valid,
    input  logic [CMD_AW-1:0] beat_addr,
    input  logic [7:0]        beat_data,
    input  logic              busy,
    output nfc_req_t          req,
    output logic              dec_idle
);

    seq_t st;
    seq_t st_nxt;

    function automatic logic hit(input logic [CMD_AW-1:0] a, input logic [7:0] d);
        return (beat_addr == a) && (beat_data == d);
    endfunction

    always_comb begin
        st_nxt    = st;
        req.kind  = REQ_NONE;
        req.data  = beat_data;
        if (beat_valid && !busy) begin
            st_nxt = SQ_IDLE;
            unique case (st)
                SQ_IDLE:  if (hit(KEY_ADDR_A, KEY_DATA_A)) st_nxt = SQ_KEY1;
                SQ_KEY1:  if (hit(KEY_ADDR_B, KEY_DATA_B)) st_nxt = SQ_KEY2;
                SQ_KEY2: begin
                    if (hit(KEY_ADDR_A, CODE_PROG))     st_nxt = SQ_PDATA;
                    else if (hit(KEY_ADDR_A, CODE_EXT)) st_nxt = SQ_EXT;
                end
                SQ_PDATA: req.kind = REQ_PGM;
                SQ_EXT:   if (hit(KEY_ADDR_A, KEY_DATA_A)) st_nxt = SQ_KEY3;
                SQ_KEY3:  if (hit(KEY_ADDR_B, KEY_DATA_B)) st_nxt = SQ_KEY4;
                SQ_KEY4: begin
                    if (hit(KEY_ADDR_A, CODE_ERASE))     req.kind = REQ_ERS;
                    else if (hit(KEY_ADDR_A, CODE_LOCK)) req.kind = REQ_LCK;
                end
                default: st_nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_nxt;
    end

    assign dec_idle = (st == SQ_IDLE);

endmodule

// File: rtl/nfc_op_engine.sv
module nfc_op_engine
    import nfc_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MEM_AW    = 9,
    parameter int BOOT_AW   = 14,
    parameter bit BOOT_TOP  = 1'b0,
    parameter int PROG_CYC  = 30,
    parameter int ERASE_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  nfc_req_t          req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              locked,
    output logic [7:0]        rd_byte
);

    localparam int DEPTH = 1 << MEM_AW;
    localparam int HALF  = DEPTH / 2;
    localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [7:0]    stat;
    logic          req_boot;
    logic          rd_boot;

    generate
        if (BOOT_TOP) begin : g_top
            assign req_boot = &req_addr[ADDR_W-1:BOOT_AW];
            assign rd_boot  = &rd_addr[ADDR_W-1:BOOT_AW];
        end else begin : g_bottom
            assign req_boot = ~|req_addr[ADDR_W-1:BOOT_AW];
            assign rd_boot  = ~|rd_addr[ADDR_W-1:BOOT_AW];
        end
    endgenerate

    logic [MEM_AW-1:0] req_idx;
    logic [MEM_AW-1:0] rd_idx;
    assign req_idx = {~req_boot, req_addr[MEM_AW-2:0]};
    assign rd_idx  = {~rd_boot,  rd_addr[MEM_AW-2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
            busy   <= 1'b0;
            locked <= 1'b0;
            cnt    <= '0;
            stat   <= 8'h00;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else begin
            unique case (req.kind)
                REQ_PGM: begin
                    if (!(locked && req_boot)) begin
                        mem[req_idx] <= mem[req_idx] & req.data;
                        busy         <= 1'b1;
                        cnt          <= CW'(PROG_CYC - 1);
                        stat         <= prog_status(req.data);
                    end
                end
                REQ_ERS: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (!(locked && (i < HALF))) mem[i] <= ERASED_BYTE;
                    end
                    busy <= 1'b1;
                    cnt  <= CW'(ERASE_CYC - 1);
                    stat <= 8'h00;
                end
                REQ_LCK: locked <= 1'b1;
                default: ;
            endcase
        end
    end

    assign rd_byte = busy ? stat : mem[rd_idx];

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nfc_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MEM_AW    = 9,
    parameter int BOOT_AW   = 14,
    parameter bit BOOT_TOP  = 1'b0,
    parameter int PROG_CYC  = 30,
    parameter int ERASE_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);

    logic              beat_valid;
    logic [ADDR_W-1:0] beat_addr;
    logic [7:0]        beat_data;
    nfc_req_t          req;
    logic              dec_idle;
    logic              busy;
    logic              locked;
    logic [7:0]        rd_byte;

    nfc_bus_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .addr       (addr),
        .dq_in      (dq_in),
        .beat_valid (beat_valid),
        .beat_addr  (beat_addr),
        .beat_data  (beat_data)
    );

    nfc_seq_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (beat_valid),
        .beat_addr  (beat_addr[CMD_AW-1:0]),
        .beat_data  (beat_data),
        .busy       (busy),
        .req        (req),
        .dec_idle   (dec_idle)
    );

    nfc_op_engine #(
        .ADDR_W    (ADDR_W),
        .MEM_AW    (MEM_AW),
        .BOOT_AW   (BOOT_AW),
        .BOOT_TOP  (BOOT_TOP),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_addr (beat_addr),
        .rd_addr  (addr),
        .busy     (busy),
        .locked   (locked),
        .rd_byte  (rd_byte)
    );

    assign dq_oe  = ~ce_n & ~oe_n & we_n;
    assign dq_out = dq_oe ? rd_byte : 8'h00;

endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
    parameter int PROG_CYC  = 30,
    parameter int ERASE_CYC = 200
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       locked,
    input logic       dec_idle,
    input logic       beat_valid,
    input logic       dq_oe,
    input logic [7:0] dq_out
);

    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1;
        else           run <= '0;
    end

    // R6 / R7: a busy period only begins right after a write beat closes
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(beat_valid));

    // R6 / R7: busy lasts exactly one of the two configured lengths
    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (($past(run) + 1 == PROG_CYC) || ($past(run) + 1 == ERASE_CYC)));

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> locked);

    p_idle_while_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> dec_idle);

    p_status_low_bits_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && dq_oe) |-> (dq_out[6:0] == 7'b0));

endmodule

bind nor_cmd_ctrl nfc_checker #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .locked     (locked),
    .dec_idle   (dec_idle),
    .beat_valid (beat_valid),
    .dq_oe      (dq_oe),
    .dq_out     (dq_out)
);

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;

    localparam int CLK_NS = 10;
    localparam int AW  = 19;
    localparam int MAW = 6;
    localparam int BAW = 14;
    localparam int PC  = 6;
    localparam int EC  = 20;
    localparam int NB  = 1 << MAW;
    localparam int HB  = NB / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = 8'h00;
    logic [7:0]    dq_out;
    logic          dq_oe;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [7:0] exp_mem [NB];

    always #(CLK_NS/2) clk = ~clk;

    nor_cmd_ctrl #(
        .ADDR_W(AW), .MEM_AW(MAW), .BOOT_AW(BAW), .BOOT_TOP(1'b0),
        .PROG_CYC(PC), .ERASE_CYC(EC)
    ) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [AW-1:0] boot_a(input int i);
        return AW'(i);
    endfunction
    function automatic logic [AW-1:0] main_a(input int i);
        return AW'(32'h10000 + i);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check(dq_oe === 1'b1 && dq_out === e, tag, int'(dq_out), int'(e));
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        bus_write(AW'(32'h5555), 8'hAA);
        bus_write(AW'(32'h2AAA), 8'h55);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        unlock();
        bus_write(AW'(32'h5555), 8'hA0);
        bus_write(a, d);
    endtask

    task automatic ext_cmd(input logic [7:0] code);
        unlock();
        bus_write(AW'(32'h5555), 8'h80);
        unlock();
        bus_write(AW'(32'h5555), code);
    endtask

    function automatic int bidx(input logic [AW-1:0] a);
        logic boot;
        boot = (a[AW-1:BAW] == '0);
        return int'({~boot, a[MAW-2:0]});
    endfunction

    task automatic read_all(input string tag);
        for (int i = 0; i < HB; i++) read_chk(boot_a(i), exp_mem[i], tag);
        for (int i = 0; i < HB; i++) read_chk(main_a(i), exp_mem[HB + i], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: no drive when select or read enable high
        ce_n = 1'b0; oe_n = 1'b1; #1;
        check(dq_oe === 1'b0, "R2 oe_n high", int'(dq_oe), 0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        check(dq_oe === 1'b0, "R2 ce_n high", int'(dq_oe), 0);
        oe_n = 1'b1;

        // R3 / R1 / R12: erased after reset
        read_all("R3 reset erased");

        // R4 / R6 / R10 on one program, with exact busy window
        prog(boot_a(0), 8'h5A);
        exp_mem[0] = 8'h5A;
        read_chk(boot_a(9), 8'h80, "R10 program status");
        repeat (PC - 1) @(negedge clk);
        read_chk(boot_a(0), 8'h80, "R6 still busy at PROG_CYC-1");
        @(negedge clk);
        read_chk(boot_a(0), 8'h5A, "R6 done at PROG_CYC");

        // R4 / R12 sweep, two passes, bytes AND together
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < NB; i++) begin
                logic [7:0] d;
                logic [AW-1:0] a;
                d = (pass == 0) ? 8'((i * 37 + 5)) : 8'((i * 91) ^ 8'h5A);
                a = (i < HB) ? boot_a(i) : main_a(i - HB);
                prog(a, d);
                exp_mem[bidx(a)] = exp_mem[bidx(a)] & d;
                read_chk(a, {~d[7], 7'b0}, "R10 status in sweep");
                repeat (PC) @(negedge clk);
            end
            read_all("R4 program AND sweep");
        end

        // R5: address at overlap start, data at overlap end, skewed strobes
        unlock();
        bus_write(AW'(32'h5555), 8'hA0);
        @(negedge clk); addr = main_a(5); dq_in = 8'h00; we_n = 1'b0;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); addr = main_a(6); dq_in = 8'h00;
        @(negedge clk); dq_in = 8'hF0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        exp_mem[HB + 5] = exp_mem[HB + 5] & 8'hF0;
        repeat (PC) @(negedge clk);
        read_chk(main_a(5), exp_mem[HB + 5], "R5 first address, last data");
        read_chk(main_a(6), exp_mem[HB + 6], "R5 later address untouched");

        // R11: broken sequences start nothing
        bus_write(AW'(32'h5555), 8'hAA);
        bus_write(AW'(32'h2AAB), 8'h55);
        bus_write(AW'(32'h5555), 8'hA0);
        bus_write(main_a(7), 8'h00);
        read_chk(main_a(7), exp_mem[HB + 7], "R11 wrong address ignored");
        bus_write(AW'(32'h5555), 8'hAA);
        bus_write(AW'(32'h2AAA), 8'h54);
        bus_write(AW'(32'h5555), 8'hA0);
        bus_write(main_a(7), 8'h00);
        read_chk(main_a(7), exp_mem[HB + 7], "R11 wrong data ignored");

        // R7 / R10 / R11: erase, with a program attempted while busy
        ext_cmd(8'h10);
        for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
        read_chk(main_a(3), 8'h00, "R10 erase status");
        prog(main_a(3), 8'h00);
        repeat (EC - 1 - 12) @(negedge clk);
        read_chk(main_a(3), 8'h00, "R7 still busy at ERASE_CYC-1");
        @(negedge clk);
        read_all("R7 erase and R11 busy writes ignored");

        // R8 / R9: lock
        prog(boot_a(2), 8'h3C); repeat (PC) @(negedge clk);
        prog(main_a(2), 8'h3C); repeat (PC) @(negedge clk);
        exp_mem[2] = 8'h3C; exp_mem[HB + 2] = 8'h3C;
        ext_cmd(8'h40);
        read_chk(boot_a(2), 8'h3C, "R8 lock has no busy period");
        prog(boot_a(2), 8'h00);
        read_chk(boot_a(2), 8'h3C, "R9 boot program ignored");
        prog(main_a(2), 8'h0F);
        read_chk(main_a(2), 8'h80, "R9 main program still runs");
        repeat (PC) @(negedge clk);
        exp_mem[HB + 2] = 8'h0C;
        read_chk(main_a(2), 8'h0C, "R9 main program result");
        ext_cmd(8'h10);
        repeat (EC) @(negedge clk);
        for (int i = HB; i < NB; i++) exp_mem[i] = 8'hFF;
        read_all("R9 erase keeps boot window");
        prog(boot_a(1), 8'h00);
        read_chk(boot_a(1), 8'hFF, "R8 lock survives erase");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule